// File: doc/BRIEF.md
# PDM Digital Microphone Capture Front-End

This block clocks external pulse-density-modulated microphones and gathers their one-bit streams from a small number of shared data pins. The system clock is divided down to one of three microphone clock rates, and each rate has its own high and low phase lengths, so the slowest rate can run with an uneven duty cycle. A capture strobe fires a fixed number of system cycles after every microphone clock edge. The strobe is placed after the point where the microphone has settled its output, and well before the next edge.

Each data pin serves one channel pair. A pin runs in one of two modes. In single-talker mode one microphone drives the pin, and its bit, sampled after the rising edge, feeds both channels of the pair. In shared mode two microphones take turns: the even channel is sampled after the rising edge and the odd channel after the falling edge. An optional per-pair swap exchanges the two channels. Every channel then passes a level stage that forwards the stream, halves it, or silences it, and emits a valid-qualified bit that goes to a later decimator.

The clock generator is a four-state machine. IDLE holds the clock low. IDLE goes to ARM when enable is high and the rate code is legal; ARM latches the rate. ARM goes to HIGH after one cycle. HIGH goes to LOW when the high count expires, and LOW goes back to HIGH when the low count expires. From ARM, HIGH or LOW the machine returns to IDLE as soon as enable drops or the rate code differs from the latched rate.

Top module: `pdm_mic_frontend`

## Requirements
- R1: Rate code 0 gives a microphone clock high for HI_R0 and low for LO_R0 system cycles (60/40 by default). Code 1 uses HI_R1/LO_R1 and code 2 uses HI_R2/LO_R2 (both 50/50 by default).
- R2: When enable is low or rate code 3 is selected, dmic_clk is low from the following cycle onward and no channel valid is produced.
- R3: A rate-code change while running drives dmic_clk low on the next cycle and keeps it low one more cycle. The clock then rises on the third cycle after the change and stays high for the full high count of the new rate.
- R4: With mux_mode[p]=0 (single-talker), the pin bit sampled after each rising edge is delivered on both channels 2p and 2p+1, and both valids are asserted together.
- R5: With mux_mode[p]=1 (shared), channel 2p carries the bit sampled after the rising edge and channel 2p+1 the bit sampled after the falling edge, each with its own valid.
- R6: A channel valid is asserted exactly CAP_DLY+2 system cycles after the first high (or first low) cycle of dmic_clk that launched its sample.
- R7: swap_lr[p]=1 exchanges channels 2p and 2p+1 (data and valid) ahead of the level stage.
- R8: The level field level[2c+1:2c] of channel c uses these codes, where n is that channel's sample index since the last start: 0 forwards the input; 1 replaces samples with odd n by bit 1 of n; 2 or 3 outputs bit 0 of n (an alternating 0,1 idle pattern).
- R9: The per-channel sample index restarts at zero whenever the clock restarts, so the first muted sample after any start is 0.
- R10: Reset and any stop clear the outputs, and ch_vld is low from the second cycle after enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the microphone clock |
| rate_sel | input | 2 | Rate code 0..2; 3 keeps the clock stopped |
| mux_mode | input | N_PINS | Per pin: 0 single-talker, 1 shared (two microphones) |
| swap_lr | input | N_PINS | Per pair: exchange the two channels |
| level | input | 2*NCH | Two-bit level code per channel |
| dmic_data | input | N_PINS | Microphone data pins |
| dmic_clk | output | 1 | Microphone clock |
| ch_bit | output | NCH | Per-channel PDM bit |
| ch_vld | output | NCH | Per-channel bit valid |

## Verification
The embedded properties assume that mux_mode, swap_lr and level are held steady while the clock runs, and that enable and rate_sel are the only inputs that move mid-stream. They also assume that a data pin changes only between strobes and that each phase count exceeds CAP_DLY. The bench changes the configuration only after enable has been low for several cycles. It moves a data pin half a system cycle after it sees a microphone clock edge, which is well before the strobe and after the previous one. The bench parameters keep every phase at least two cycles longer than the strobe delay.

// File: rtl/pdm_fe_pkg.sv
package pdm_fe_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARM  = 2'd1,
        PH_HIGH = 2'd2,
        PH_LOW  = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        LV_PASS = 2'd0,
        LV_HALF = 2'd1,
        LV_MUTE = 2'd2,
        LV_SILN = 2'd3
    } level_t;

    localparam logic [1:0] RATE_STOP = 2'd3;

endpackage

// File: rtl/pdm_fe_clkgen.sv
module pdm_fe_clkgen
    import pdm_fe_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int HI_R0 = 24,
    parameter int LO_R0 = 16,
    parameter int HI_R1 = 15,
    parameter int LO_R1 = 15,
    parameter int HI_R2 = 10,
    parameter int LO_R2 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] rate_sel,
    output logic       mic_clk,
    output logic       rise_p,
    output logic       fall_p,
    output logic       active
);

    phase_t             st, st_nxt;
    logic [1:0]         cur_rate;
    logic [CNT_W-1:0]   cnt, cnt_nxt;
    logic [CNT_W-1:0]   hi_cnt, lo_cnt;

    always_comb begin
        unique case (cur_rate)
            2'd0: begin
                hi_cnt = CNT_W'(HI_R0);
                lo_cnt = CNT_W'(LO_R0);
            end
            2'd1: begin
                hi_cnt = CNT_W'(HI_R1);
                lo_cnt = CNT_W'(LO_R1);
            end
            default: begin
                hi_cnt = CNT_W'(HI_R2);
                lo_cnt = CNT_W'(LO_R2);
            end
        endcase
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            PH_IDLE: begin
                if (enable && rate_sel != RATE_STOP) begin
                    st_nxt = PH_ARM;
                end
            end
            PH_ARM: begin
                st_nxt  = PH_HIGH;
                cnt_nxt = hi_cnt - CNT_W'(1);
            end
            PH_HIGH: begin
                if (cnt == '0) begin
                    st_nxt  = PH_LOW;
                    cnt_nxt = lo_cnt - CNT_W'(1);
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            PH_LOW: begin
                if (cnt == '0) begin
                    st_nxt  = PH_HIGH;
                    cnt_nxt = hi_cnt - CNT_W'(1);
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
        endcase
        if (st != PH_IDLE && (!enable || rate_sel != cur_rate)) begin
            st_nxt  = PH_IDLE;
            cnt_nxt = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= PH_IDLE;
            cnt      <= '0;
            cur_rate <= 2'd0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
            if (st == PH_IDLE && st_nxt == PH_ARM) begin
                cur_rate <= rate_sel;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mic_clk <= 1'b0;
            rise_p  <= 1'b0;
            fall_p  <= 1'b0;
            active  <= 1'b0;
        end else begin
            mic_clk <= (st_nxt == PH_HIGH);
            rise_p  <= (st_nxt == PH_HIGH) && (st != PH_HIGH);
            fall_p  <= (st_nxt == PH_LOW) && (st == PH_HIGH);
            active  <= (st_nxt == PH_HIGH) || (st_nxt == PH_LOW);
        end
    end

    // phase-length observers for the properties below
    logic [CNT_W-1:0] hrun, lrun;
    logic             lo_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hrun    <= '0;
            lrun    <= '0;
            lo_seen <= 1'b0;
        end else begin
            hrun    <= mic_clk ? hrun + CNT_W'(1) : '0;
            lrun    <= mic_clk ? '0 : lrun + CNT_W'(1);
            lo_seen <= fall_p ? 1'b1 : (active ? lo_seen : 1'b0);
        end
    end

    // R1
    hi_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mic_clk) && active |-> hrun == hi_cnt);

    // R1
    lo_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mic_clk) && lo_seen |-> lrun == lo_cnt);

    // R2
    stop_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable || rate_sel == RATE_STOP |=> !mic_clk);

    // R3
    restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> mic_clk && rise_p);

endmodule

// File: rtl/pdm_fe_capture.sv
module pdm_fe_capture #(
    parameter int N_PINS  = 2,
    parameter int CAP_DLY = 3,
    localparam int NCH    = 2 * N_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              rise_p,
    input  logic              fall_p,
    input  logic [N_PINS-1:0] mux_mode,
    input  logic [N_PINS-1:0] swap_lr,
    input  logic [N_PINS-1:0] pin,
    output logic [NCH-1:0]    raw_bit,
    output logic [NCH-1:0]    raw_vld
);

    logic [CAP_DLY-1:0] rpipe, fpipe;
    logic               rstb, fstb;
    logic [NCH-1:0]     cap_bit, cap_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpipe <= '0;
            fpipe <= '0;
        end else if (!active) begin
            rpipe <= '0;
            fpipe <= '0;
        end else begin
            rpipe[0] <= rise_p;
            fpipe[0] <= fall_p;
            for (int i = 1; i < CAP_DLY; i++) begin
                rpipe[i] <= rpipe[i-1];
                fpipe[i] <= fpipe[i-1];
            end
        end
    end

    assign rstb = rpipe[CAP_DLY-1];
    assign fstb = fpipe[CAP_DLY-1];

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cap_bit[2*p+:2] <= 2'b00;
                cap_vld[2*p+:2] <= 2'b00;
            end else if (!active) begin
                cap_bit[2*p+:2] <= 2'b00;
                cap_vld[2*p+:2] <= 2'b00;
            end else begin
                cap_vld[2*p]   <= rstb;
                cap_vld[2*p+1] <= mux_mode[p] ? fstb : rstb;
                if (rstb) begin
                    cap_bit[2*p] <= pin[p];
                    if (!mux_mode[p]) begin
                        cap_bit[2*p+1] <= pin[p];
                    end
                end
                if (fstb && mux_mode[p]) begin
                    cap_bit[2*p+1] <= pin[p];
                end
            end
        end

        always_comb begin
            if (swap_lr[p]) begin
                raw_bit[2*p]   = cap_bit[2*p+1];
                raw_bit[2*p+1] = cap_bit[2*p];
                raw_vld[2*p]   = cap_vld[2*p+1];
                raw_vld[2*p+1] = cap_vld[2*p];
            end else begin
                raw_bit[2*p+:2] = cap_bit[2*p+:2];
                raw_vld[2*p+:2] = cap_vld[2*p+:2];
            end
        end

        // R4
        single_pair_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_vld[2*p+1] && !$past(mux_mode[p]) |-> cap_vld[2*p]);

        // R6
        even_vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_vld[2*p] |=> !cap_vld[2*p]);
    end

    // R2
    vld_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |cap_vld |-> $past(active));

endmodule

// File: rtl/pdm_fe_level.sv
module pdm_fe_level
    import pdm_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       in_bit,
    input  logic       in_vld,
    input  logic [1:0] level,
    output logic       out_bit,
    output logic       out_vld
);

    logic [1:0] idx;
    logic       nb;
    logic       is_mute;

    assign is_mute = (level_t'(level) == LV_MUTE) || (level_t'(level) == LV_SILN);

    always_comb begin
        unique case (level_t'(level))
            LV_PASS: nb = in_bit;
            LV_HALF: nb = idx[0] ? idx[1] : in_bit;
            LV_MUTE: nb = idx[0];
            LV_SILN: nb = idx[0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= 2'd0;
            out_bit <= 1'b0;
            out_vld <= 1'b0;
        end else if (!active) begin
            idx     <= 2'd0;
            out_bit <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_bit <= nb;
                idx     <= idx + 2'd1;
            end
        end
    end

    // observers for the idle-pattern properties
    logic mute_q, seen_q, prev_mute, last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mute_q    <= 1'b0;
            seen_q    <= 1'b0;
            prev_mute <= 1'b0;
            last_bit  <= 1'b0;
        end else if (!active) begin
            mute_q    <= 1'b0;
            seen_q    <= 1'b0;
            prev_mute <= 1'b0;
            last_bit  <= 1'b0;
        end else begin
            if (in_vld) begin
                mute_q <= is_mute;
            end
            if (out_vld) begin
                seen_q    <= 1'b1;
                prev_mute <= mute_q;
                last_bit  <= out_bit;
            end
        end
    end

    // R8
    mute_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && mute_q && prev_mute |-> out_bit != last_bit);

    // R9
    mute_first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && mute_q && !seen_q |-> !out_bit);

    // R10
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !out_vld);

endmodule

// File: rtl/pdm_mic_frontend.sv
module pdm_mic_frontend
    import pdm_fe_pkg::*;
#(
    parameter int N_PINS  = 2,
    parameter int CNT_W   = 8,
    parameter int HI_R0   = 24,
    parameter int LO_R0   = 16,
    parameter int HI_R1   = 15,
    parameter int LO_R1   = 15,
    parameter int HI_R2   = 10,
    parameter int LO_R2   = 10,
    parameter int CAP_DLY = 3,
    localparam int NCH    = 2 * N_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        rate_sel,
    input  logic [N_PINS-1:0] mux_mode,
    input  logic [N_PINS-1:0] swap_lr,
    input  logic [2*NCH-1:0]  level,
    input  logic [N_PINS-1:0] dmic_data,
    output logic              dmic_clk,
    output logic [NCH-1:0]    ch_bit,
    output logic [NCH-1:0]    ch_vld
);

    logic           rise_p, fall_p, active;
    logic [NCH-1:0] raw_bit, raw_vld;

    pdm_fe_clkgen #(
        .CNT_W (CNT_W),
        .HI_R0 (HI_R0),
        .LO_R0 (LO_R0),
        .HI_R1 (HI_R1),
        .LO_R1 (LO_R1),
        .HI_R2 (HI_R2),
        .LO_R2 (LO_R2)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .rate_sel (rate_sel),
        .mic_clk  (dmic_clk),
        .rise_p   (rise_p),
        .fall_p   (fall_p),
        .active   (active)
    );

    pdm_fe_capture #(
        .N_PINS  (N_PINS),
        .CAP_DLY (CAP_DLY)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .rise_p   (rise_p),
        .fall_p   (fall_p),
        .mux_mode (mux_mode),
        .swap_lr  (swap_lr),
        .pin      (dmic_data),
        .raw_bit  (raw_bit),
        .raw_vld  (raw_vld)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pdm_fe_level u_level (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (active),
            .in_bit  (raw_bit[c]),
            .in_vld  (raw_vld[c]),
            .level   (level[2*c+:2]),
            .out_bit (ch_bit[c]),
            .out_vld (ch_vld[c])
        );
    end

    // R2
    no_vld_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |ch_vld |-> $past(active));

endmodule

// File: tb/test_pdm_mic_frontend.sv
module test_pdm_mic_frontend;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NP  = 2;
    localparam int NC  = 4;
    localparam int CD  = 2;
    localparam int LAT = CD + 2;
    localparam int HI_T [3] = '{6, 5, 4};
    localparam int LO_T [3] = '{4, 5, 4};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [1:0]    rate_sel = 2'd0;
    logic [NP-1:0] mux_mode = '0;
    logic [NP-1:0] swap_lr = '0;
    logic [7:0]    level = '0;
    logic [NP-1:0] dmic_data = '0;
    logic          dmic_clk;
    logic [NC-1:0] ch_bit, ch_vld;

    always #2.5 clk = ~clk;

    pdm_mic_frontend #(
        .N_PINS(NP), .CNT_W(6),
        .HI_R0(6), .LO_R0(4), .HI_R1(5), .LO_R1(5), .HI_R2(4), .LO_R2(4),
        .CAP_DLY(CD)
    ) i_pdm_mic_frontend (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel),
        .mux_mode(mux_mode), .swap_lr(swap_lr), .level(level),
        .dmic_data(dmic_data), .dmic_clk(dmic_clk), .ch_bit(ch_bit), .ch_vld(ch_vld)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic gen(input int p, input int e, input int k);
        int v;
        v = k * 29 + p * 71 + e * 113 + (k >> 2) * 7;
        return ^(v[7:0] & 8'h6d);
    endfunction

    // microphone model and stream monitor
    int   cyc = 0;
    int   rise_cyc = 0, fall_cyc = 0;
    bit   have_rise = 0, have_fall = 0;
    bit   mon_on = 0;
    logic prev_clk = 1'b0;
    logic rbit [NP];
    logic fbit [NP];
    int   rcnt [NP];
    int   fcnt [NP];
    int   ncnt [NC];
    int   vcnt [NC];

    initial begin
        for (int p = 0; p < NP; p++) begin
            rbit[p] = 1'b0; fbit[p] = 1'b0; rcnt[p] = 0; fcnt[p] = 0;
        end
        for (int c = 0; c < NC; c++) begin
            ncnt[c] = 0; vcnt[c] = 0;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (dmic_clk && !prev_clk && have_fall)
                chk(cyc - fall_cyc == LO_T[rate_sel], "R1 low phase", cyc - fall_cyc, LO_T[rate_sel]);
            if (!dmic_clk && prev_clk && have_rise)
                chk(cyc - rise_cyc == HI_T[rate_sel], "R1 high phase", cyc - rise_cyc, HI_T[rate_sel]);
        end
        if (dmic_clk && !prev_clk) begin
            rise_cyc = cyc;
            if (mon_on) have_rise = 1;
        end
        if (!dmic_clk && prev_clk) begin
            fall_cyc = cyc;
            if (mon_on) have_fall = 1;
        end
        if (mon_on) begin
            for (int c = 0; c < NC; c++) begin
                if (ch_vld[c]) begin
                    int   p, j, n, lat;
                    bit   efall;
                    logic d, e;
                    p = c / 2;
                    j = swap_lr[p] ? (c ^ 1) : c;
                    efall = mux_mode[p] && (j % 2 == 1);
                    d = efall ? fbit[p] : rbit[p];
                    lat = cyc - (efall ? fall_cyc : rise_cyc);
                    // R4 R5 R6 R7: source edge and latency
                    chk(lat == LAT, "R6 valid latency", lat, LAT);
                    n = ncnt[c];
                    case (level[2*c+:2])
                        2'd0: e = d;
                        2'd1: e = (n % 2 == 1) ? logic'((n / 2) % 2) : d;
                        default: e = logic'(n % 2);
                    endcase
                    // R8 R5 R4 R7: data after routing and level stage
                    chk(ch_bit[c] == e, "R8 channel data", int'(ch_bit[c]), int'(e));
                    ncnt[c] = n + 1;
                    vcnt[c]++;
                end
            end
        end
        if (dmic_clk && !prev_clk) begin
            for (int p = 0; p < NP; p++) begin
                rbit[p] = gen(p, 0, rcnt[p]); rcnt[p]++; dmic_data[p] = rbit[p];
            end
        end
        if (!dmic_clk && prev_clk) begin
            for (int p = 0; p < NP; p++) begin
                fbit[p] = gen(p, 1, fcnt[p]); fcnt[p]++; dmic_data[p] = fbit[p];
            end
        end
        prev_clk = dmic_clk;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] lvl_pat(input int lp);
        case (lp)
            0: return 8'h00;
            1: return 8'h91;
            default: return 8'h4E;
        endcase
    endfunction

    task automatic run_cfg(input int r, input int m, input int s, input int lp);
        mon_on = 0;
        enable = 1'b0;
        repeat (4) step();
        rate_sel = 2'(r); mux_mode = 2'(m); swap_lr = 2'(s); level = lvl_pat(lp);
        for (int c = 0; c < NC; c++) begin
            ncnt[c] = 0; vcnt[c] = 0;
        end
        have_rise = 0; have_fall = 0;
        enable = 1'b1;
        mon_on = 1;
        repeat (40) step();
        mon_on = 0;
        for (int c = 0; c < NC; c++)
            chk(vcnt[c] >= 3, "R5 R4 valid count", vcnt[c], 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hl;
        bit bad;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10 reset state
        chk(dmic_clk == 1'b0, "R10 reset clock", int'(dmic_clk), 0);
        chk(ch_vld == '0, "R10 reset valid", int'(ch_vld), 0);

        // R2 stop code keeps everything quiet
        rate_sel = 2'd3; enable = 1'b1;
        bad = 0;
        repeat (30) begin
            step();
            if (dmic_clk || ch_vld != '0) bad = 1;
        end
        chk(!bad, "R2 rate code 3 idle", int'(bad), 0);
        enable = 1'b0;
        repeat (3) step();

        // R3 and R9: rate change mid-high, muted channel 0
        rate_sel = 2'd0; mux_mode = 2'b00; swap_lr = 2'b00; level = 8'h02;
        enable = 1'b1;
        step();
        while (!ch_vld[0]) step();
        chk(ch_bit[0] == 1'b0, "R9 first muted bit", int'(ch_bit[0]), 0);
        rate_sel = 2'd2;
        step();
        chk(dmic_clk == 1'b0, "R3 clock drops", int'(dmic_clk), 0);
        step();
        chk(dmic_clk == 1'b0, "R3 clock gap", int'(dmic_clk), 0);
        step();
        chk(dmic_clk == 1'b1, "R3 clock restart", int'(dmic_clk), 1);
        hl = 1;
        step();
        while (dmic_clk) begin
            hl++;
            step();
        end
        chk(hl == HI_T[2], "R3 full first high", hl, HI_T[2]);
        while (!ch_vld[0]) step();
        chk(ch_bit[0] == 1'b0, "R9 index restarted", int'(ch_bit[0]), 0);
        step();
        while (!ch_vld[0]) step();
        chk(ch_bit[0] == 1'b1, "R8 mute alternates", int'(ch_bit[0]), 1);

        // R10 stop clears outputs
        step();
        while (!ch_vld[0]) step();
        enable = 1'b0;
        step();
        chk(dmic_clk == 1'b0, "R2 clock low after stop", int'(dmic_clk), 0);
        bad = 0;
        repeat (20) begin
            step();
            if (ch_vld != '0) bad = 1;
        end
        chk(!bad, "R10 valids cleared", int'(bad), 0);

        // sweep: R1 R4 R5 R6 R7 R8
        for (int r = 0; r < 3; r++)
            for (int m = 0; m < 4; m++)
                for (int s = 0; s < 4; s++)
                    for (int lp = 0; lp < 3; lp++)
                        run_cfg(r, m, s, lp);

        enable = 1'b0;
        repeat (4) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule